// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a synthesizable behavioural model of a small dynamic memory. The memory is a grid of multi-bit supercells, and it is reached through one narrow address port that is shared between two phases. With the default parameters the grid has 4 rows and 4 columns of 8-bit supercells, so 128 bits in total. Each supercell is named by its (row, column) pair.

A row strobe samples the shared address as a row index and copies that whole row into an internal row buffer, which opens the row. A column strobe then samples the address as a column index and acts on the open row. A read returns the buffered supercell. A write updates both the buffer and the array, so the new value survives the row being closed. A refresh request takes a row index, rewrites that row with its own contents and closes any open row. An error flag reports a column strobe that arrives while no row is open. Electrical timing and charge loss are not modelled.

Top module: `dram_mux_model`

## Requirements
- R1: After reset, `rdata` is 0, `err` is 0, no row is open and every supercell holds 0.
- R2: On a clock edge where `row_stb` is high and `ref_req` is low, `addr` is taken as the row index and that row becomes the open row.
- R3: On a clock edge where `col_stb` is high, `row_stb` and `ref_req` are low, `wr_en` is low and a row is open, `rdata` shows supercell (open row, `addr`) from the next cycle, and `err` goes to 0.
- R4: `rdata` and `err` keep their values on every cycle that has no accepted column strobe.
- R5: An accepted column strobe while no row is open sets `err` to 1 and `rdata` to 0 from the next cycle, and it changes no supercell.
- R6: An accepted column strobe with `wr_en` high on an open row stores `wdata` at (open row, `addr`) and shows `wdata` on `rdata` from the next cycle. Later reads of that column in the same open row return it.
- R7: A written value stays in the array after the row is closed and reopened, and every other supercell keeps its value.
- R8: On a clock edge where `ref_req` is high, the row that `addr` names is rewritten unchanged and any open row is closed. A following column strobe reports the error of R5.
- R9: When several strobes are high on one edge, `ref_req` wins over `row_stb`, and `row_stb` wins over `col_stb`. A column strobe that loses this arbitration has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb | input | 1 | Row strobe: sample `addr` as a row and open it |
| col_stb | input | 1 | Column strobe: sample `addr` as a column and access it |
| wr_en | input | 1 | With `col_stb`: 1 writes, 0 reads |
| ref_req | input | 1 | Refresh the row on `addr` and close the open row |
| addr | input | AW (2) | Shared row and column address |
| wdata | input | W (8) | Write data |
| rdata | output | W (8) | Read data, registered, held until the next column strobe |
| err | output | 1 | Column access was made with no open row |

## Verification
A wrong row index latched by the row strobe, or a row buffer that no longer matches the array, shows at the ports as a wrong `rdata` one cycle after the next read column strobe. A write that reaches the buffer but not the array stays hidden until that row is closed and reopened. A wrong open/closed state shows as a wrong `err` one cycle after the next column strobe. The bench compares `rdata` and `err` with a flat reference memory on every cycle, so any of these faults is reported on the first cycle its effect reaches the ports.

// File: rtl/dram_mux_model.sv
module dram_mux_model #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int W    = 8,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW  = (RW > CW) ? RW : CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_stb,
  input  logic          col_stb,
  input  logic          wr_en,
  input  logic          ref_req,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          err
);

  logic [W-1:0]  cells  [ROWS][COLS];
  logic [W-1:0]  rowbuf [COLS];
  logic          open_q;
  logic [RW-1:0] row_q;
  logic [W-1:0]  rdata_q;
  logic          err_q;

  wire           do_row = row_stb & ~ref_req;
  wire           do_col = col_stb & ~row_stb & ~ref_req;
  wire [RW-1:0]  row_a  = addr[RW-1:0];
  wire [CW-1:0]  col_a  = addr[CW-1:0];

  assign rdata = rdata_q;
  assign err   = err_q;

  // Array: refresh senses a row and writes it back; column writes land here too.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cells[r][c] <= '0;
    end else if (ref_req) begin
      for (int c = 0; c < COLS; c++)
        cells[row_a][c] <= cells[row_a][c];
    end else if (do_col && open_q && wr_en) begin
      cells[row_q][col_a] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++)
        rowbuf[c] <= '0;
    end else if (do_row) begin
      for (int c = 0; c < COLS; c++)
        rowbuf[c] <= cells[row_a][c];
    end else if (do_col && open_q && wr_en) begin
      rowbuf[col_a] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (ref_req) begin
      open_q <= 1'b0;
    end else if (do_row) begin
      open_q <= 1'b1;
      row_q  <= row_a;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (do_col) begin
      err_q <= ~open_q;
      if (!open_q)    rdata_q <= '0;
      else if (wr_en) rdata_q <= wdata;
      else            rdata_q <= rowbuf[col_a];
    end
  end

endmodule

module dram_mux_model_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         row_stb,
  input logic         col_stb,
  input logic         ref_req,
  input logic [W-1:0] rdata,
  input logic         err
);

  logic acc_col;
  assign acc_col = col_stb & ~row_stb & ~ref_req;

  // R4 and R9: outputs move only after an accepted column strobe
  a_r4_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_col |=> ($stable(rdata) && $stable(err)));

  // R5: an error response always carries zero data
  a_r5_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rdata == '0));

  // R8: refresh leaves no row open for the next column access
  a_r8_refresh_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |=> (acc_col |=> err));

  // R2: a row strobe opens a row for the next column access
  a_r2_row_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb && !ref_req) |=> (acc_col |=> !err));

endmodule

bind dram_mux_model dram_mux_model_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb),
  .ref_req(ref_req), .rdata(rdata), .err(err)
);

// File: tb/dram_mux_model_tb_top.sv
module dram_mux_model_tb_top;
  localparam int ROWS = 4, COLS = 4, W = 8, AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_stb = 0, col_stb = 0, wr_en = 0, ref_req = 0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          err;

  int n_cmp = 0, n_bad = 0;
  int mem [ROWS*COLS];
  bit m_open = 0;
  int m_row = 0, m_rd = 0;
  bit m_err = 0;

  always #10 clk = ~clk;

  dram_mux_model #(.ROWS(ROWS), .COLS(COLS), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb),
    .wr_en(wr_en), .ref_req(ref_req), .addr(addr), .wdata(wdata),
    .rdata(rdata), .err(err)
  );

  task automatic compare(input string tag);
    n_cmp++;
    if (rdata !== W'(m_rd) || err !== m_err) begin
      n_bad++;
      $display("FAIL %s: rdata=%0h err=%0b expected rdata=%0h err=%0b",
               tag, rdata, err, m_rd[W-1:0], m_err);
    end
  endtask

  task automatic cyc(input bit rf, input bit rs, input bit cs, input bit we,
                     input int a, input int d, input string tag);
    ref_req = rf; row_stb = rs; col_stb = cs; wr_en = we;
    addr = AW'(a); wdata = W'(d);
    @(posedge clk);
    if (rf) m_open = 0;
    else if (rs) begin m_open = 1; m_row = a; end
    else if (cs) begin
      if (!m_open) begin m_err = 1; m_rd = 0; end
      else begin
        m_err = 0;
        if (we) begin mem[m_row*COLS+a] = d & 8'hFF; m_rd = d & 8'hFF; end
        else m_rd = mem[m_row*COLS+a];
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset outputs");
    cyc(0, 0, 1, 0, 1, 0, "R1 R5 no open row after reset");
    idle("R4 error held");
    cyc(0, 1, 0, 0, 2, 0, "R2 open row 2");
    cyc(0, 0, 1, 0, 1, 0, "R1 R3 cell (2,1) zero after reset");
    // fill every cell
    for (int r = 0; r < ROWS; r++) begin
      cyc(0, 1, 0, 0, r, 0, "R2 open row");
      for (int c = 0; c < COLS; c++)
        cyc(0, 0, 1, 1, c, 8'h5A ^ (r*16+c*3+1), "R6 write echo");
    end
    // read back all
    for (int r = ROWS-1; r >= 0; r--) begin
      cyc(0, 1, 0, 0, r, 0, "R2 R7 reopen row");
      for (int c = 0; c < COLS; c++) begin
        cyc(0, 0, 1, 0, c, 0, "R3 R7 read back");
        idle("R4 hold read");
      end
    end
    // write then read in same open row
    cyc(0, 1, 0, 0, 1, 0, "R2 open row 1");
    cyc(0, 0, 1, 1, 3, 8'hC3, "R6 write (1,3)");
    cyc(0, 0, 1, 0, 0, 0, "R7 neighbour (1,0) kept");
    cyc(0, 0, 1, 0, 3, 0, "R6 read (1,3) from buffer");
    // refresh closes the row
    cyc(1, 0, 0, 0, 1, 0, "R8 refresh row 1");
    cyc(0, 0, 1, 0, 3, 0, "R8 R5 col after refresh");
    cyc(0, 0, 1, 1, 2, 8'hEE, "R5 write ignored when closed");
    cyc(0, 1, 0, 0, 1, 0, "R2 reopen row 1");
    cyc(0, 0, 1, 0, 3, 0, "R8 R7 data kept over refresh");
    cyc(0, 0, 1, 0, 2, 0, "R5 closed write left (1,2)");
    // priority
    cyc(0, 1, 0, 0, 0, 0, "R2 open row 0");
    cyc(1, 1, 1, 1, 2, 8'h11, "R9 refresh wins");
    cyc(0, 0, 1, 0, 2, 0, "R9 R8 row closed after combined");
    cyc(0, 1, 1, 1, 3, 8'h22, "R9 row wins over col");
    cyc(0, 0, 1, 0, 2, 0, "R9 R2 row 3 open, (3,2) unchanged");
    cyc(0, 0, 1, 0, 0, 0, "R3 read (3,0)");
    cyc(1, 0, 1, 0, 3, 0, "R9 col under refresh ignored");
    idle("R4 hold");
    cyc(0, 1, 0, 0, 2, 0, "R2 open row 2");
    cyc(0, 0, 1, 0, 1, 0, "R7 (2,1) written value");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule